// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is a purely combinational 32-bit integer arithmetic and logic unit. It is built from a row of identical one-bit cells. Each cell holds an AND gate, an OR gate, a full adder, an optional inversion of its B bit, and a four-way output selector. Carries ripple from each cell to the next higher one. Three small helper units sit around the row:

- a signed-compare unit that feeds the lowest cell;
- a signed-overflow unit;
- a zero detector on the final result.

A 3-bit operation code selects the function. Its two low bits are the selector code inside every cell. Its top bit turns on B inversion everywhere and also drives the carry into the lowest cell. Subtraction is therefore computed as A plus the complement of B plus one. The signed compare reuses that subtraction. It decides from the sign bits of A, B and the difference, so the answer stays right when the difference itself overflows. Op-codes outside the defined set produce an all-zero result with no carry and no overflow.

Top module: `bitslice_alu`

## Requirements
- R1: Op-code 3'b000 gives result = A & B (bitwise).
- R2: Op-code 3'b001 gives result = A | B (bitwise).
- R3: Op-code 3'b010 gives result = (A + B) mod 2^32, and carry_out is bit 32 of the unsigned 33-bit sum.
- R4: Op-code 3'b110 gives result = (A - B) mod 2^32, and carry_out is bit 32 of A + ~B + 1 (1 exactly when A >= B as unsigned numbers).
- R5: Op-code 3'b111 gives result bit 0 = 1 exactly when A < B as signed two's-complement numbers, with bits 31..1 all 0. This holds even when A - B overflows.
- R6: For op-code 3'b010, overflow is 1 exactly when A and B share a sign bit and the result's sign bit differs from it.
- R7: For op-code 3'b110, overflow is 1 exactly when the sign bits of A and B differ and the result's sign bit differs from A's sign bit.
- R8: Overflow is 0 for op-codes 3'b000, 3'b001 and 3'b111.
- R9: zero is 1 exactly when all 32 result bits are 0, for every op-code.
- R10: Op-codes 3'b011, 3'b100 and 3'b101 give result 0, carry_out 0 and overflow 0 (so zero is 1).
- R11: For op-codes 3'b000 and 3'b001, carry_out is bit 32 of the unsigned sum A + B. For 3'b111 it is the subtraction carry of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 3 | Operation code |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry out of the highest cell |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The bench drives signed compares whose difference overflows, such as the most negative value against 1 and the most positive value against -1. A compare that only looked at the difference's sign bit would invert its answer on exactly these pairs. It aims at the overflow boundaries of add and subtract in both sign directions, which catch a swapped or inverted sign condition. It also covers an add whose result wraps to zero with a carry, which would expose a zero flag taken from the carry or the raw adder. Finally it applies the three unused op-codes and logic operations on operands whose sum carries, which shows whether the carry chain or the selector leaks into those outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // Cell selector codes carried on the two low op-code bits
    localparam logic [1:0] SEL_AND  = 2'b00;
    localparam logic [1:0] SEL_OR   = 2'b01;
    localparam logic [1:0] SEL_SUM  = 2'b10;
    localparam logic [1:0] SEL_LESS = 2'b11;

    function automatic logic op_is_defined(input logic [OP_W-1:0] code);
        return (code == OP_AND) || (code == OP_OR) || (code == OP_ADD) ||
               (code == OP_SUB) || (code == OP_SLT);
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       binv_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  logic [1:0] sel_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    logic b_eff_d;
    logic and_d;
    logic or_d;

    always_comb begin
        b_eff_d = binv_i ? ~b_i : b_i;
        and_d   = a_i & b_eff_d;
        or_d    = a_i | b_eff_d;
        sum_o   = a_i ^ b_eff_d ^ cin_i;
        cout_o  = (a_i & b_eff_d) | (a_i & cin_i) | (b_eff_d & cin_i);
        case (sel_i)
            SEL_AND:  res_o = and_d;
            SEL_OR:   res_o = or_d;
            SEL_SUM:  res_o = sum_o;
            default:  res_o = less_i;
        endcase
    end

endmodule

// File: rtl/alu_slt_unit.sv
module alu_slt_unit (
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic diff_msb_i,
    output logic less_o
);

    // Differing signs: the negative operand is the smaller one.
    // Equal signs: the difference cannot overflow, so its sign decides.
    always_comb begin
        if (a_msb_i != b_msb_i) less_o = a_msb_i;
        else                    less_o = diff_msb_i;
    end

endmodule

// File: rtl/alu_ovf_unit.sv
module alu_ovf_unit
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            a_msb_i,
    input  logic            b_msb_i,
    input  logic            r_msb_i,
    output logic            ovf_o
);

    always_comb begin
        unique case (op_i)
            OP_ADD:  ovf_o = (a_msb_i == b_msb_i) && (r_msb_i != a_msb_i);
            OP_SUB:  ovf_o = (a_msb_i != b_msb_i) && (r_msb_i != a_msb_i);
            default: ovf_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_unit.sv
module alu_zero_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             zero_o
);

    always_comb zero_o = ~(|value_i);

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             zero,
    output logic             overflow
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             carry;
        logic             ovf;
    } alu_out_t;

    logic [WIDTH:0]   carry_chain;
    logic [WIDTH-1:0] cell_res;
    logic [WIDTH-1:0] cell_sum;
    logic [WIDTH-1:0] less_vec;
    logic             less_w;
    logic             ovf_w;
    logic             zero_w;
    logic             unused_sum_low;
    alu_out_t         out_d;

    assign carry_chain[0] = op[2];

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            if (i == 0) begin : g_less_src
                assign less_vec[i] = less_w;
            end else begin : g_less_tie
                assign less_vec[i] = 1'b0;
            end

            alu_bit_slice u_cell (
                .a_i    (a[i]),
                .b_i    (b[i]),
                .binv_i (op[2]),
                .cin_i  (carry_chain[i]),
                .less_i (less_vec[i]),
                .sel_i  (op[1:0]),
                .res_o  (cell_res[i]),
                .sum_o  (cell_sum[i]),
                .cout_o (carry_chain[i+1])
            );
        end
    endgenerate

    // Only the top sum bit is consumed (by the compare and overflow units)
    assign unused_sum_low = ^cell_sum[MSB-1:0];

    alu_slt_unit u_slt (
        .a_msb_i    (a[MSB]),
        .b_msb_i    (b[MSB]),
        .diff_msb_i (cell_sum[MSB]),
        .less_o     (less_w)
    );

    alu_ovf_unit u_ovf (
        .op_i    (op),
        .a_msb_i (a[MSB]),
        .b_msb_i (b[MSB]),
        .r_msb_i (cell_sum[MSB]),
        .ovf_o   (ovf_w)
    );

    always_comb begin
        out_d = '0;
        if (op_is_defined(op)) begin
            out_d.result = cell_res;
            out_d.carry  = carry_chain[WIDTH];
            out_d.ovf    = ovf_w;
        end
    end

    alu_zero_unit #(.WIDTH(WIDTH)) u_zero (
        .value_i (out_d.result),
        .zero_o  (zero_w)
    );

    assign result    = out_d.result;
    assign carry_out = out_d.carry;
    assign overflow  = out_d.ovf;
    assign zero      = zero_w;

endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [2:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             zero,
    input logic             overflow
);

    logic [WIDTH:0]   ref_add;
    logic [WIDTH:0]   ref_sub;
    logic signed [WIDTH+1:0] s_add;
    logic signed [WIDTH+1:0] s_sub;
    logic             ref_lt;

    always_comb begin
        ref_add = {1'b0, a} + {1'b0, b};
        ref_sub = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
        s_add   = $signed({{2{a[WIDTH-1]}}, a}) + $signed({{2{b[WIDTH-1]}}, b});
        s_sub   = $signed({{2{a[WIDTH-1]}}, a}) - $signed({{2{b[WIDTH-1]}}, b});
        ref_lt  = $signed(a) < $signed(b);

        if (op == 3'b000) begin
            p_and_r1: assert (result == (a & b)) else $error("R1 and mismatch");
        end
        if (op == 3'b001) begin
            p_or_r2: assert (result == (a | b)) else $error("R2 or mismatch");
        end
        if (op == 3'b010) begin
            p_add_r3: assert ({carry_out, result} == ref_add) else $error("R3 add mismatch");
            p_ovf_add_r6: assert (overflow == (s_add[WIDTH+1:WIDTH-1] != {3{s_add[WIDTH-1]}}))
                else $error("R6 add overflow mismatch");
        end
        if (op == 3'b110) begin
            p_sub_r4: assert ({carry_out, result} == ref_sub) else $error("R4 sub mismatch");
            p_ovf_sub_r7: assert (overflow == (s_sub[WIDTH+1:WIDTH-1] != {3{s_sub[WIDTH-1]}}))
                else $error("R7 sub overflow mismatch");
        end
        if (op == 3'b111) begin
            p_slt_r5: assert (result == {{(WIDTH-1){1'b0}}, ref_lt}) else $error("R5 slt mismatch");
        end
        if (op == 3'b000 || op == 3'b001 || op == 3'b111) begin
            p_no_overflow_r8: assert (!overflow) else $error("R8 overflow on non-arith op");
        end
        p_zero_r9: assert (zero == (result == '0)) else $error("R9 zero flag mismatch");
        if (op == 3'b011 || op == 3'b100 || op == 3'b101) begin
            p_unused_r10: assert (result == '0 && !carry_out && !overflow)
                else $error("R10 unused op not quiet");
        end
    end

endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .a         (a),
    .b         (b),
    .op        (op),
    .result    (result),
    .carry_out (carry_out),
    .zero      (zero),
    .overflow  (overflow)
);

// File: tb/sim_bitslice_alu.sv
`timescale 1ns/1ps
module sim_bitslice_alu;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] result;
    logic         carry_out;
    logic         zero;
    logic         overflow;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bitslice_alu #(.WIDTH(W)) u0 (
        .a(a), .b(b), .op(op),
        .result(result), .carry_out(carry_out), .zero(zero), .overflow(overflow)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [2:0] ov);
        @(posedge clk);
        a  = av;
        b  = bv;
        op = ov;
        @(negedge clk);
    endtask

    // Reference outputs computed from the requirements
    task automatic expect_all(input string req, input logic [W-1:0] av,
                              input logic [W-1:0] bv, input logic [2:0] ov);
        logic [W:0]   s_add;
        logic [W:0]   s_sub;
        longint       sa;
        longint       sb;
        longint       wide;
        logic [W-1:0] e_res;
        logic         e_c;
        logic         e_v;
        s_add = {1'b0, av} + {1'b0, bv};
        s_sub = {1'b0, av} + {1'b0, ~bv} + 33'd1;
        sa = longint'($signed(av));
        sb = longint'($signed(bv));
        e_res = '0; e_c = 1'b0; e_v = 1'b0;
        case (ov)
            3'b000: begin e_res = av & bv; e_c = s_add[W]; end
            3'b001: begin e_res = av | bv; e_c = s_add[W]; end
            3'b010: begin
                e_res = s_add[W-1:0]; e_c = s_add[W];
                wide = sa + sb;
                e_v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            3'b110: begin
                e_res = s_sub[W-1:0]; e_c = s_sub[W];
                wide = sa - sb;
                e_v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            3'b111: begin e_res = {31'd0, (sa < sb)}; e_c = s_sub[W]; end
            default: ;
        endcase
        apply(av, bv, ov);
        check(req, "result", result, e_res);
        check(req, "carry_out", {31'd0, carry_out}, {31'd0, e_c});
        check(req, "overflow", {31'd0, overflow}, {31'd0, e_v});
        check("R9", "zero", {31'd0, zero}, {31'd0, (e_res == '0)});
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R9", "initial zero", {31'd0, zero}, 32'd1);
        check("R1", "initial result", result, '0);
    endtask

    task automatic t_logic;
        expect_all("R1", 32'hF0F0_A5A5, 32'hFF00_0FF0, 3'b000);
        expect_all("R2", 32'hF0F0_A5A5, 32'h0F00_0FF0, 3'b001);
        expect_all("R11", 32'h8000_0001, 32'h8000_0001, 3'b000);  // sum carries
        expect_all("R11", 32'hFFFF_FFFF, 32'h0000_0001, 3'b001);
        expect_all("R8", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b001);
        expect_all("R1", 32'h5555_5555, 32'hAAAA_AAAA, 3'b000);  // all-zero AND
    endtask

    task automatic t_add;
        expect_all("R3", 32'd12345, 32'd67890, 3'b010);
        expect_all("R6", 32'h7FFF_FFFF, 32'd1, 3'b010);
        expect_all("R6", 32'h8000_0000, 32'h8000_0000, 3'b010);  // wraps to 0, carry
        expect_all("R3", 32'hFFFF_FFFF, 32'd1, 3'b010);
        expect_all("R6", 32'h8000_0000, 32'hFFFF_FFFF, 3'b010);
        expect_all("R6", 32'h7FFF_FFFF, 32'h8000_0000, 3'b010);
    endtask

    task automatic t_sub;
        expect_all("R4", 32'd100, 32'd30, 3'b110);
        expect_all("R4", 32'd30, 32'd100, 3'b110);
        expect_all("R4", 32'd0, 32'd0, 3'b110);
        expect_all("R7", 32'h8000_0000, 32'd1, 3'b110);
        expect_all("R7", 32'd0, 32'h8000_0000, 3'b110);
        expect_all("R7", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
        expect_all("R7", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 3'b110);
    endtask

    task automatic t_slt;
        expect_all("R5", 32'h8000_0000, 32'd1, 3'b111);          // diff overflows
        expect_all("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);  // diff overflows
        expect_all("R5", 32'hFFFF_FFFB, 32'hFFFF_FFFD, 3'b111);
        expect_all("R5", 32'd7, 32'd7, 3'b111);
        expect_all("R5", 32'd3, 32'd9, 3'b111);
        expect_all("R8", 32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
    endtask

    task automatic t_unused;
        expect_all("R10", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
        expect_all("R10", 32'h8000_0000, 32'h8000_0000, 3'b100);
        expect_all("R10", 32'h1234_5678, 32'h1234_5678, 3'b101);
    endtask

    initial begin
        t_reset_state();
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule